// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on one output line. Bytes wait in a 64-entry holding FIFO. A frame engine takes each byte in turn and sends it as a start bit, the data bits least-significant first, an optional parity bit and one or more stop bits. Frame shape comes from an 8-bit line-configuration word. That word picks the data width, the stop length, the parity mode (none, odd, even, or a constant bit) and a break override. Bit timing is counted on a 16x oversampling tick supplied from outside. One bit time is 16 ticks.

The shape fields of the configuration word are latched when a byte is taken from the FIFO. A change while a frame is in flight only affects later frames. The break field acts at once on the line. Two flags report progress: holding-empty (no bytes waiting in the FIFO) and transmitter-empty (FIFO empty and no frame in flight). A full flag lets the host throttle its writes. A write made while the FIFO is full is discarded.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the line is high, holding-empty and transmitter-empty are 1, and the full flag is 0.
- R2: A frame starts with a low start bit and then sends data least-significant bit first, each bit lasting 16 ticks of `tick16`. The line is high when idle.
- R3: `line_cfg[1:0]` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Higher byte bits are not sent.
- R4: With `line_cfg[2]`=0 the stop part lasts 16 ticks. With `line_cfg[2]`=1 it lasts 24 ticks for 5-bit words and 32 ticks otherwise. When bytes are queued, the next start bit follows the stop part with no gap.
- R5: `line_cfg[3]`=1 adds a parity bit after the data. `line_cfg[4]`=1 makes the count of ones in data plus parity even, and 0 makes it odd. With `line_cfg[3]`=0 no parity bit is sent.
- R6: With `line_cfg[3]`=1 and `line_cfg[5]`=1 the parity bit is constant: 1 when `line_cfg[4]`=0, and 0 when `line_cfg[4]`=1. `line_cfg[5]` has no effect when `line_cfg[3]`=0.
- R7: While `line_cfg[6]`=1 the line is low, whether or not a frame is in flight. When it clears, the line shows the frame or idle level again.
- R8: `hold_empty` is 1 exactly when the FIFO holds no byte. A byte written to an idle block sits in the FIFO for one cycle before the engine takes it.
- R9: `tx_empty` is 1 only when the FIFO is empty and no frame is in flight.
- R10: The FIFO holds 64 bytes and raises `fifo_full` when it holds 64. A write while full is dropped. Bytes go out in write order.
- R11: `line_cfg[7]` has no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x oversampling tick, one cycle wide |
| line_cfg | input | 8 | Frame configuration word |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to transmit |
| tx_o | output | 1 | Serial line |
| hold_empty | output | 1 | No byte waiting in the FIFO |
| tx_empty | output | 1 | FIFO empty and engine idle |
| fifo_full | output | 1 | FIFO holds its maximum count |

## Verification
A wrong bit counter or state in the frame engine shows at the line within one bit time. The monitor samples every bit at mid-bit and would see a stop level where data belongs, or the reverse. A stop counter that is off by even one tick moves the next start edge of a back-to-back burst, and the monitor measures that spacing exactly in ticks. A FIFO pointer or count fault shows as bytes out of order, repeated or lost, or as a wrong `fifo_full`/`hold_empty` value in the cycle after the write that should change it.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int TICKS_PER_BIT = 16;

    // Field layout of the 8-bit configuration word (MSB first).
    typedef struct packed {
        logic       spare;      // [7]
        logic       brk;        // [6]
        logic       stick;      // [5]
        logic       even;       // [4]
        logic       par_en;     // [3]
        logic       long_stop;  // [2]
        logic [1:0] len;        // [1:0]
    } frame_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic [5:0] stop_ticks(input frame_cfg_t c);
        if (!c.long_stop)      return 6'd16;
        else if (c.len == 2'd0) return 6'd24;
        else                   return 6'd32;
    endfunction

    function automatic logic parity_bit(input frame_cfg_t c, input logic [7:0] d);
        logic [7:0] used;
        used = d & (8'hFF >> (2'd3 - c.len));
        if (c.stick) return ~c.even;
        if (c.even)  return ^used;
        return ~(^used);
    endfunction

endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push, pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> $stable(wr_ptr));
    assert_read_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);

endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       pop,
    output logic       busy,
    output logic       line
);
    tx_state_e  state;
    logic [4:0] sub;
    logic [2:0] bit_idx;
    logic [7:0] shreg;
    logic [3:0] nbits;
    logic       par_on;
    logic       par_val;
    logic [5:0] stop_len;
    logic [5:0] limit;
    logic       bit_done;

    assign limit    = (state == ST_STOP) ? stop_len : 6'(TICKS_PER_BIT);
    assign bit_done = tick && ({1'b0, sub} == limit - 6'd1);
    assign busy     = (state != ST_IDLE);
    assign pop      = !fifo_empty &&
                      ((state == ST_IDLE) || (state == ST_STOP && bit_done));

    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_val;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sub      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            nbits    <= 4'd8;
            par_on   <= 1'b0;
            par_val  <= 1'b0;
            stop_len <= 6'd16;
        end else if (pop) begin
            state    <= ST_START;
            sub      <= '0;
            bit_idx  <= '0;
            shreg    <= fifo_data;
            nbits    <= data_bits(cfg.len);
            par_on   <= cfg.par_en;
            par_val  <= parity_bit(cfg, fifo_data);
            stop_len <= stop_ticks(cfg);
        end else if (busy && tick) begin
            if (bit_done) begin
                sub <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg   <= shreg >> 1;
                        bit_idx <= bit_idx + 3'd1;
                        if ({1'b0, bit_idx} == nbits - 4'd1)
                            state <= par_on ? ST_PAR : ST_STOP;
                    end
                    ST_PAR:  state <= ST_STOP;
                    default: state <= ST_IDLE;
                endcase
            end else begin
                sub <= sub + 5'd1;
            end
        end
    end

    assert_start_after_pop_R2: assert property (@(posedge clk) disable iff (rst)
        pop |=> (line == 1'b0));
    assert_sub_bound_R4: assert property (@(posedge clk) disable iff (rst)
        {1'b0, sub} < limit);
    assert_data_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> ({1'b0, bit_idx} < nbits));

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic [7:0] line_cfg,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       tx_o,
    output logic       hold_empty,
    output logic       tx_empty,
    output logic       fifo_full
);
    frame_cfg_t cfg;
    logic       cfg_unused;
    logic       fifo_empty;
    logic [7:0] fifo_data;
    logic       pop;
    logic       busy;
    logic       line;

    assign cfg        = frame_cfg_t'(line_cfg);
    assign cfg_unused = cfg.spare;

    tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (fifo_data),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    tx_frame_engine engine_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick16),
        .cfg        (cfg),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .pop        (pop),
        .busy       (busy),
        .line       (line)
    );

    assign tx_o       = cfg.brk ? 1'b0 : line;
    assign hold_empty = fifo_empty;
    assign tx_empty   = fifo_empty && !busy;

    assert_break_low_R7: assert property (@(posedge clk) disable iff (rst)
        line_cfg[6] |-> !tx_o);
    assert_empty_order_R9: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);
    assert_full_not_empty_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !hold_empty);

endmodule

// File: tb/uart_tx_core_tb_top.sv
module uart_tx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic [7:0] line_cfg = 8'h03;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_o, hold_empty, tx_empty, fifo_full;

    uart_tx_core dut_i (
        .clk(clk), .rst(rst), .tick16(tick16), .line_cfg(line_cfg),
        .wr_en(wr_en), .wr_data(wr_data), .tx_o(tx_o),
        .hold_empty(hold_empty), .tx_empty(tx_empty), .fifo_full(fifo_full)
    );

    always #4 clk = ~clk;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  tick_en = 1'b1;
    int  tick_div = 1;
    int  phase = 0;
    int  tcount = 0;
    bit  mon_en = 1'b1;
    bit  mon_busy = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        logic [7:0] data;
        int         nbits;
        int         par;
        int         stop_t;
        bit         b2b;
    } exp_t;
    exp_t exp_q[$];

    always @(negedge clk) begin
        if (tick_en && phase == 0) tick16 = 1'b1;
        else                       tick16 = 1'b0;
        phase = (phase + 1 >= tick_div) ? 0 : phase + 1;
    end

    always @(posedge clk) if (tick16) tcount <= tcount + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_parity(input logic [7:0] c, input logic [7:0] d, input int nb);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += d[i];
        if (!c[3]) return -1;
        if (c[5])  return c[4] ? 0 : 1;
        if (c[4])  return ones % 2;
        return 1 - (ones % 2);
    endfunction

    task automatic send(input logic [7:0] d, input bit b2b);
        exp_t e;
        e.data   = d;
        e.nbits  = 5 + int'(line_cfg[1:0]);
        e.par    = exp_parity(line_cfg, d, e.nbits);
        e.stop_t = !line_cfg[2] ? 16 : (line_cfg[1:0] == 2'd0 ? 24 : 32);
        e.b2b    = b2b;
        exp_q.push_back(e);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic raw_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk);
        while (!(tx_empty && exp_q.size() == 0 && !mon_busy));
        repeat (3) @(negedge clk);
    endtask

    // Monitor: takes expected frames off the queue as starts appear on the line.
    initial begin
        int prev_t0 = 0;
        int prev_len = 0;
        forever begin
            @(negedge clk);
            if (mon_en && !rst && tx_o == 1'b0) begin
                int   t0;
                exp_t e;
                mon_busy = 1'b1;
                t0 = tcount;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected frame start", 1, 0);
                    while (tx_o == 1'b0) @(negedge clk);
                end else begin
                    e = exp_q.pop_front();
                    if (e.b2b)
                        chk(t0 - prev_t0 == prev_len, "R4", "frame spacing in ticks",
                            t0 - prev_t0, prev_len);
                    while (tcount < t0 + 8) @(negedge clk);
                    chk(tx_o == 1'b0, "R2", "start bit", int'(tx_o), 0);
                    for (int i = 0; i < e.nbits; i++) begin
                        while (tcount < t0 + 16 * (1 + i) + 8) @(negedge clk);
                        chk(tx_o == e.data[i], "R3", $sformatf("data bit %0d of %02h", i, e.data),
                            int'(tx_o), int'(e.data[i]));
                    end
                    if (e.par >= 0) begin
                        while (tcount < t0 + 16 * (1 + e.nbits) + 8) @(negedge clk);
                        chk(int'(tx_o) == e.par, "R5", $sformatf("parity of %02h", e.data),
                            int'(tx_o), e.par);
                    end
                    prev_len = 16 * (1 + e.nbits + (e.par >= 0 ? 1 : 0));
                    while (tcount < t0 + prev_len + 8) @(negedge clk);
                    chk(tx_o == 1'b1, "R4", "stop bit level", int'(tx_o), 1);
                    prev_len += e.stop_t;
                    prev_t0 = t0;
                end
                mon_busy = 1'b0;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_o == 1'b1, "R1", "idle line", int'(tx_o), 1);
        chk(hold_empty == 1'b1, "R1", "hold_empty", int'(hold_empty), 1);
        chk(tx_empty == 1'b1, "R1", "tx_empty", int'(tx_empty), 1);
        chk(fifo_full == 1'b0, "R1", "fifo_full", int'(fifo_full), 0);

        // R2 8 data bits, no parity, one stop, back-to-back
        line_cfg = 8'h03;
        send(8'h55, 1'b0); send(8'hA3, 1'b1); send(8'h00, 1'b1); send(8'hFF, 1'b1);
        wait_idle();

        // R2 slower tick: every third cycle
        tick_div = 3;
        send(8'h96, 1'b0); send(8'h3C, 1'b1);
        wait_idle();
        tick_div = 1;

        // R3 R4 5-bit with 1.5 stop bits; upper bits of 0xE0 not sent
        line_cfg = 8'h04;
        send(8'h15, 1'b0); send(8'hE0, 1'b1); send(8'h0A, 1'b1);
        wait_idle();

        // R4 R5 6-bit, 2 stop, even parity
        line_cfg = 8'h1D;
        send(8'h2D, 1'b0); send(8'h3F, 1'b1);
        wait_idle();

        // R5 7-bit odd parity, one stop
        line_cfg = 8'h0A;
        send(8'h41, 1'b0); send(8'h00, 1'b1);
        wait_idle();

        // R6 constant parity 1 then 0
        line_cfg = 8'h2B;
        send(8'hFF, 1'b0); send(8'h01, 1'b1);
        wait_idle();
        line_cfg = 8'h3B;
        send(8'hFF, 1'b0); send(8'h01, 1'b1);
        wait_idle();
        // R6 constant bit ignored without parity enable
        line_cfg = 8'h23;
        send(8'h81, 1'b0); send(8'h7E, 1'b1);
        wait_idle();

        // R11 bit 7 set behaves like plain 8N1
        line_cfg = 8'h83;
        send(8'hC5, 1'b0); send(8'h5C, 1'b1);
        wait_idle();
        line_cfg = 8'h03;

        // R8 R9 R10 flags and fill with ticks stopped
        tick_en = 1'b0;
        send(8'h10, 1'b0);
        chk(hold_empty == 1'b0, "R8", "byte waiting one cycle", int'(hold_empty), 0);
        chk(tx_empty == 1'b0, "R9", "tx_empty with byte waiting", int'(tx_empty), 0);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R8", "taken by engine", int'(hold_empty), 1);
        chk(tx_empty == 1'b0, "R9", "tx_empty while frame in flight", int'(tx_empty), 0);
        for (int i = 0; i < 63; i++) send(8'(8'h20 + i), 1'b1);
        chk(fifo_full == 1'b0, "R10", "full after 63 queued", int'(fifo_full), 0);
        chk(hold_empty == 1'b0, "R8", "hold_empty with bytes queued", int'(hold_empty), 0);
        send(8'h99, 1'b1);
        chk(fifo_full == 1'b1, "R10", "full after 64 queued", int'(fifo_full), 1);
        raw_write(8'hEE);
        chk(fifo_full == 1'b1, "R10", "full after dropped write", int'(fifo_full), 1);
        tick_en = 1'b1;
        @(negedge clk);
        chk(tx_o == 1'b0, "R7", "start bit before break", int'(tx_o), 0);
        wait_idle();
        chk(exp_q.size() == 0, "R10", "all queued frames seen", exp_q.size(), 0);

        // R7 break at idle and over a frame in flight
        mon_en = 1'b0;
        line_cfg = 8'h43;
        repeat (5) @(negedge clk);
        chk(tx_o == 1'b0, "R7", "break at idle", int'(tx_o), 0);
        chk(tx_empty == 1'b1, "R9", "tx_empty during idle break", int'(tx_empty), 1);
        line_cfg = 8'h03;
        @(negedge clk);
        chk(tx_o == 1'b1, "R7", "idle after break", int'(tx_o), 1);
        raw_write(8'hFF);
        repeat (40) @(negedge clk);
        chk(tx_o == 1'b1, "R7", "data one before break", int'(tx_o), 1);
        line_cfg = 8'h43;
        @(negedge clk);
        chk(tx_o == 1'b0, "R7", "break over frame", int'(tx_o), 0);
        repeat (30) @(negedge clk);
        chk(tx_o == 1'b0, "R7", "break still over frame", int'(tx_o), 0);
        line_cfg = 8'h03;
        @(negedge clk);
        chk(tx_o == 1'b1, "R7", "frame level after break", int'(tx_o), 1);
        do @(negedge clk); while (!tx_empty);
        chk(tx_o == 1'b1, "R2", "idle high after frame", int'(tx_o), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule